// File: doc/BRIEF.md
# Victim Line Buffer with Swap-on-Hit

This block is a small, fully associative store that sits beside a direct-mapped first-level cache and holds lines that cache has recently thrown out. When the first-level cache misses, it presents the wanted block address here, together with the line it is about to overwrite. All stored tags are compared at once. If the wanted line is present, it is handed back and the outgoing first-level line takes its slot, so the two lines trade places without any traffic to the next level. If the wanted line is absent, a next-level read request is raised, and the outgoing line is kept here. It fills a free slot when there is one and otherwise replaces the least recently used entry. A dirty entry that is pushed out produces a writeback.

Each entry keeps the full block address (tag and index bits of the first-level cache), a valid bit, a dirty bit and the line data. Lines enter only through the displaced-line fields that come with a lookup. Lookups that the first-level cache hits never reach this block.

The controller has four states. `ST_IDLE` waits for a lookup and moves to `ST_PROBE` when it accepts one. `ST_PROBE` compares all tags and moves to `ST_HIT` on a match or to `ST_MISS` otherwise. `ST_HIT` and `ST_MISS` each last one cycle, present the response and return to `ST_IDLE`.

Top module: `victim_cache_swap`

## Requirements
- R1: After reset the store is empty, `lk_ready` is 1, and `resp_valid`, `nl_req` and `wb_valid` are 0.
- R2: A lookup is accepted on a clock edge where `lk_req` and `lk_ready` are both 1. `lk_ready` stays 0 from that edge until the response cycle has ended.
- R3: The response of a lookup appears two clock edges after acceptance and lasts one cycle. On a hit, `resp_hit` is 1, `resp_data` and `resp_dirty` are the stored line's, and `nl_req` stays 0.
- R4: On a hit, the displaced line (fields `ev_*`, sampled at acceptance) takes the hit entry's slot. If `ev_valid` was 0, that slot becomes empty, and a later lookup of the same address misses.
- R5: On a miss, `resp_hit` is 0, and `nl_req` is 1 with `nl_addr` equal to the lookup address in the same cycle.
- R6: On a miss with `ev_valid` 1, the displaced line is stored in an empty entry if one exists. Otherwise it replaces the least recently used entry.
- R7: Recency is updated whenever a valid line is written into an entry, whether by a miss insertion or by a swap on a hit. A plain hit without a valid displaced line does not count as a use.
- R8: When a miss insertion replaces a valid dirty entry, `wb_valid` is 1 in the response cycle, with `wb_addr` and `wb_data` set to that entry's address and data. Replacing a clean or empty entry raises no writeback.
- R9: A lookup with `ev_valid` 0 that misses stores nothing and causes no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | First-level miss lookup request |
| lk_addr | input | ADDR_W | Block address wanted by the first-level cache |
| lk_ready | output | 1 | Block can accept a lookup |
| ev_valid | input | 1 | Displaced first-level line is present |
| ev_addr | input | ADDR_W | Block address of the displaced line |
| ev_data | input | DATA_W | Data of the displaced line |
| ev_dirty | input | 1 | Displaced line is modified |
| resp_valid | output | 1 | Lookup response cycle |
| resp_hit | output | 1 | Line was found here |
| resp_data | output | DATA_W | Returned line data (valid on hit) |
| resp_dirty | output | 1 | Returned line is modified (valid on hit) |
| nl_req | output | 1 | Read request to the next level |
| nl_addr | output | ADDR_W | Address of the next-level read |
| wb_valid | output | 1 | Writeback of a pushed-out dirty line |
| wb_addr | output | ADDR_W | Writeback address |
| wb_data | output | DATA_W | Writeback data |

## Verification
The hardest case to reach from the ports is the choice between a free slot and the least recently used one. It only shows up once the store has been filled, one entry has been freed by a hit without a displaced line, and the recency order has been reshuffled by swaps. The bench gets there with a fixed chain of lookups. It fills four entries, swaps twice on the same slot, pushes out a dirty and then a clean line, and frees a slot. After that, a final insertion must land in the freed slot. A later hit on the line that true least-recently-used replacement would have evicted shows that the free slot was taken instead.

// File: rtl/vc_pkg.sv
package vc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_HIT   = 2'd2,
        ST_MISS  = 2'd3
    } vc_state_e;
endpackage

// File: rtl/vc_match.sv
module vc_match #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 12,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ADDR_W-1:0] key,
    input  logic [ADDR_W-1:0] tags [ENTRIES],
    input  logic [ENTRIES-1:0] valid,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx
);
    logic [ENTRIES-1:0] eq;

    // one comparator per entry, all in parallel
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        hit     = |eq;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid,
    output logic [IDX_W-1:0]   victim_idx
);
    // age 0 = most recent; ages always form a permutation
    logic [IDX_W-1:0] age [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)    age[i] <= '0;
                else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found_free;
        found_free = 1'b0;
        victim_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (age[i] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(i);
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid[i] && !found_free) begin
                victim_idx = IDX_W'(i);
                found_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
    import vc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lk_req,
    input  logic      probe_hit,
    output vc_state_e state,
    output logic      accept,
    output logic      lk_ready,
    output logic      resp_valid,
    output logic      resp_hit,
    output logic      nl_req
);
    vc_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (lk_req) nxt = ST_PROBE;
            ST_PROBE: nxt = probe_hit ? ST_HIT : ST_MISS;
            ST_HIT:   nxt = ST_IDLE;
            ST_MISS:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        lk_ready   = 1'b0;
        resp_valid = 1'b0;
        resp_hit   = 1'b0;
        nl_req     = 1'b0;
        unique case (state)
            ST_IDLE:  lk_ready = 1'b1;
            ST_PROBE: ;
            ST_HIT:   begin resp_valid = 1'b1; resp_hit = 1'b1; end
            ST_MISS:  begin resp_valid = 1'b1; nl_req = 1'b1; end
        endcase
        accept = lk_ready && lk_req;
    end
endmodule

// File: rtl/victim_cache_swap.sv
module victim_cache_swap
    import vc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_ready,
    input  logic              ev_valid,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              ev_dirty,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_data,
    output logic              resp_dirty,
    output logic              nl_req,
    output logic [ADDR_W-1:0] nl_addr,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ADDR_W-1:0]  tag_q   [ENTRIES];
    logic [DATA_W-1:0]  data_q  [ENTRIES];
    logic [ENTRIES-1:0] valid_q, dirty_q;

    logic [ADDR_W-1:0] req_addr_q, ev_addr_q;
    logic [DATA_W-1:0] ev_data_q;
    logic              ev_valid_q, ev_dirty_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rdirty_q, wb_pend_q;
    logic [ADDR_W-1:0] wb_addr_q;
    logic [DATA_W-1:0] wb_data_q;

    vc_state_e         state;
    logic              accept, probe_hit;
    logic [IDX_W-1:0]  hit_idx, victim_idx, slot;
    logic              write_slot, touch;

    vc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .probe_hit(probe_hit),
        .state(state), .accept(accept), .lk_ready(lk_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .nl_req(nl_req)
    );

    vc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .key(req_addr_q), .tags(tag_q), .valid(valid_q),
        .hit(probe_hit), .hit_idx(hit_idx)
    );

    vc_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(slot),
        .valid(valid_q), .victim_idx(victim_idx)
    );

    // a hit always rewrites its slot (swap or free); a miss only stores a real line
    always_comb begin
        slot       = probe_hit ? hit_idx : victim_idx;
        write_slot = (state == ST_PROBE) && (probe_hit || ev_valid_q);
        touch      = write_slot && ev_valid_q;
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            req_addr_q <= lk_addr;
            ev_valid_q <= ev_valid;
            ev_addr_q  <= ev_addr;
            ev_data_q  <= ev_data;
            ev_dirty_q <= ev_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= '0;
            dirty_q   <= '0;
            wb_pend_q <= 1'b0;
        end else begin
            if (state == ST_PROBE) begin
                rdata_q   <= data_q[hit_idx];
                rdirty_q  <= dirty_q[hit_idx];
                wb_pend_q <= !probe_hit && ev_valid_q
                             && valid_q[victim_idx] && dirty_q[victim_idx];
                wb_addr_q <= tag_q[victim_idx];
                wb_data_q <= data_q[victim_idx];
            end
            if (write_slot) begin
                valid_q[slot] <= ev_valid_q;
                dirty_q[slot] <= ev_dirty_q;
                tag_q[slot]   <= ev_addr_q;
                data_q[slot]  <= ev_data_q;
            end
        end
    end

    assign resp_data  = rdata_q;
    assign resp_dirty = rdirty_q;
    assign nl_addr    = req_addr_q;
    assign wb_valid   = (state == ST_MISS) && wb_pend_q;
    assign wb_addr    = wb_addr_q;
    assign wb_data    = wb_data_q;
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_req,
    input logic              lk_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              nl_req,
    input logic [ADDR_W-1:0] nl_addr,
    input logic              wb_valid,
    input logic [DATA_W-1:0] wb_data
);
    assert_busy_until_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !lk_ready);

    assert_resp_two_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_ready) |=> !resp_valid ##1 resp_valid);

    assert_resp_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_hit_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> !nl_req);

    assert_fetch_only_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nl_req |-> (resp_valid && !resp_hit));

    assert_wb_only_on_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (resp_valid && !resp_hit));
endmodule

bind victim_cache_swap vc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_ready(lk_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .nl_req(nl_req),
    .nl_addr(nl_addr), .wb_valid(wb_valid), .wb_data(wb_data)
);

// File: tb/tb_victim_cache_swap.sv
module tb_victim_cache_swap;
    localparam int AW = 12;
    localparam int DW = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_req = 1'b0, ev_valid = 1'b0, ev_dirty = 1'b0;
    logic [AW-1:0] lk_addr = '0, ev_addr = '0;
    logic [DW-1:0] ev_data = '0;
    logic lk_ready, resp_valid, resp_hit, resp_dirty, nl_req, wb_valid;
    logic [DW-1:0] resp_data, wb_data;
    logic [AW-1:0] nl_addr, wb_addr;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    victim_cache_swap #(.ENTRIES(4), .ADDR_W(AW), .DATA_W(DW)) dut (.*);

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {20'hA5C00, a} ^ 32'h1357_0000;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // issue one lookup; returns with outputs sampled in the response cycle
    task automatic lookup(input logic [AW-1:0] a, input logic evv,
                          input logic [AW-1:0] ea, input logic evd);
        @(negedge clk);
        lk_req = 1'b1; lk_addr = a;
        ev_valid = evv; ev_addr = ea; ev_data = pat(ea); ev_dirty = evd;
        @(negedge clk);
        lk_req = 1'b0; ev_valid = 1'b0;
        chk("R2 busy while probing", {63'd0, lk_ready}, 64'd0);
        @(negedge clk);
        chk("R3 response after two edges", {63'd0, resp_valid}, 64'd1);
        chk("R2 not ready in response", {63'd0, lk_ready}, 64'd0);
    endtask

    task automatic expect_hit(input string req, input logic [AW-1:0] a, input logic d);
        chk({req, " hit flag"}, {63'd0, resp_hit}, 64'd1);
        chk({req, " hit data"}, {32'd0, resp_data}, {32'd0, pat(a)});
        chk({req, " hit dirty"}, {63'd0, resp_dirty}, {63'd0, d});
        chk("R3 no fetch on hit", {63'd0, nl_req}, 64'd0);
    endtask

    task automatic expect_miss(input string req, input logic [AW-1:0] a);
        chk({req, " miss flag"}, {63'd0, resp_hit}, 64'd0);
        chk("R5 fetch raised", {63'd0, nl_req}, 64'd1);
        chk("R5 fetch address", {52'd0, nl_addr}, {52'd0, a});
    endtask

    task automatic expect_wb(input string req, input logic v, input logic [AW-1:0] a);
        chk({req, " writeback flag"}, {63'd0, wb_valid}, {63'd0, v});
        if (v) begin
            chk({req, " writeback addr"}, {52'd0, wb_addr}, {52'd0, a});
            chk({req, " writeback data"}, {32'd0, wb_data}, {32'd0, pat(a)});
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 ready after reset", {63'd0, lk_ready}, 64'd1);
        chk("R1 no response", {63'd0, resp_valid}, 64'd0);
        chk("R1 no fetch", {63'd0, nl_req}, 64'd0);
        chk("R1 no writeback", {63'd0, wb_valid}, 64'd0);
        lookup(12'h0AA, 1'b0, '0, 1'b0);
        expect_miss("R1 empty store", 12'h0AA);
    endtask

    task automatic t_fill;
        lookup(12'h100, 1'b1, 12'h011, 1'b1); expect_miss("R6 fill 1", 12'h100); expect_wb("R8 fill 1", 1'b0, '0);
        lookup(12'h101, 1'b1, 12'h012, 1'b0); expect_miss("R6 fill 2", 12'h101); expect_wb("R8 fill 2", 1'b0, '0);
        lookup(12'h102, 1'b1, 12'h013, 1'b0); expect_miss("R6 fill 3", 12'h102); expect_wb("R8 fill 3", 1'b0, '0);
        lookup(12'h103, 1'b1, 12'h014, 1'b0); expect_miss("R6 fill 4", 12'h103); expect_wb("R8 fill 4", 1'b0, '0);
    endtask

    task automatic t_swap;
        lookup(12'h012, 1'b1, 12'h0E1, 1'b0); expect_hit("R3", 12'h012, 1'b0);
        lookup(12'h0E1, 1'b1, 12'h0E2, 1'b0); expect_hit("R4 swapped-in line", 12'h0E1, 1'b0);
        lookup(12'h012, 1'b0, '0, 1'b0);      expect_miss("R4 swapped-out line gone", 12'h012);
    endtask

    task automatic t_lru;
        // order oldest..newest: 011(dirty), 013, 014, 0E2
        lookup(12'h200, 1'b1, 12'h021, 1'b0); expect_miss("R7", 12'h200); expect_wb("R8 dirty eviction", 1'b1, 12'h011);
        lookup(12'h201, 1'b1, 12'h022, 1'b0); expect_miss("R7", 12'h201); expect_wb("R8 clean eviction", 1'b0, '0);
        lookup(12'h011, 1'b1, 12'h033, 1'b1); expect_miss("R7 oldest evicted", 12'h011); expect_wb("R8 clean eviction", 1'b0, '0);
        lookup(12'h014, 1'b0, '0, 1'b0);      expect_miss("R7 third oldest evicted", 12'h014);
        lookup(12'h0E2, 1'b0, '0, 1'b0);      expect_hit("R7 recent line kept", 12'h0E2, 1'b0);
    endtask

    task automatic t_free_slot;
        // the 0E2 slot was freed by the hit above (R4); 0E2 is now least recent in age order
        lookup(12'h0E2, 1'b0, '0, 1'b0);      expect_miss("R4 freed slot", 12'h0E2); expect_wb("R9 no store no wb", 1'b0, '0);
        lookup(12'h033, 1'b0, '0, 1'b0);      expect_hit("R3 dirty hit", 12'h033, 1'b1);
        // 033 slot freed too; oldest valid line is 021. Insert must take a free slot
        lookup(12'h300, 1'b1, 12'h044, 1'b0); expect_miss("R6", 12'h300); expect_wb("R6 no eviction", 1'b0, '0);
        lookup(12'h021, 1'b0, '0, 1'b0);      expect_hit("R6 free slot preferred", 12'h021, 1'b0);
        lookup(12'h044, 1'b0, '0, 1'b0);      expect_hit("R6 inserted line", 12'h044, 1'b0);
        lookup(12'h022, 1'b0, '0, 1'b0);      expect_hit("R9 miss without line left store", 12'h022, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset;
        t_fill;
        t_swap;
        t_lru;
        t_free_slot;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule